// File: doc/BRIEF.md
# Rotating Register Loop Controller

This block is the loop-control part of a core that runs software-pipelined loops. It holds a loop counter, an epilogue counter and three rotating bases, one each for the general, floating and predicate register files. Combinational lookup ports turn a virtual register number into a physical one by adding the matching base inside that file's rotating window. Numbers outside the window pass through unchanged.

Before a loop, software issues a setup command. The command loads the trip count and the drain count and marks the first stage predicate true. Each loop-top branch then chooses one of three outcomes from the two counters:
- continue the kernel, which feeds a true stage predicate;
- drain the pipe, which feeds a false stage predicate;
- fall through.

On every taken loop-top branch all three bases turn by one. A plain counted branch uses only the loop counter and rotates nothing. The stage-predicate value goes out on a write port to the predicate file, which lives outside this block. Its index is computed after rotation, so on the next iteration virtual predicate 16 reads the value just written.

Top module: `rot_loop_ctrl`

## Requirements
- R1: After synchronous reset, the loop counter, the epilogue counter and all three bases are zero.
- R2: For general and floating numbers v in 32..127, the physical number is 32 + ((v - 32 + base) mod 96). Numbers 0..31 map to themselves.
- R3: For predicate numbers v in 16..63, the physical number is 16 + ((v - 16 + predicate base) mod 48). Numbers 0..15 map to themselves.
- R4: A setup command loads both counters. In the same cycle it writes true to predicate index 16 + predicate base, with the current, unrotated base.
- R5: A loop-top branch (br_kind = 1) with a nonzero loop counter is taken and decrements the loop counter. It decrements every base, wrapping 0 to 95 for general and floating and 0 to 47 for predicates. It writes true to index 16 + the new predicate base.
- R6: A loop-top branch with a zero loop counter and a nonzero epilogue counter is taken. It decrements the epilogue counter, rotates every base as in R5, and writes false to index 16 + the new predicate base.
- R7: A loop-top branch with both counters zero is not taken. It leaves the counters and bases unchanged and makes no predicate write.
- R8: A plain counted branch (br_kind = 0) is taken exactly when the loop counter is nonzero, and a taken one decrements the loop counter. Taken or not, it leaves the epilogue counter and the bases unchanged and makes no predicate write.
- R9: A base clear sets all three bases to zero and leaves both counters unchanged. A setup or branch in the same cycle is ignored: not taken and no predicate write.
- R10: When a setup and a branch arrive in the same cycle, the setup takes effect and the branch is ignored.
- R11: In a cycle with no command, the counters and bases hold their values and there is no predicate write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_bases | input | 1 | Clear all rotating bases |
| setup_en | input | 1 | Load counters and set the first stage predicate |
| setup_lc | input | LC_W (64) | Trip count to load |
| setup_ec | input | EC_W (6) | Drain count to load |
| br_valid | input | 1 | A counted branch executes this cycle |
| br_kind | input | 1 | 1 = loop-top branch with rotation, 0 = plain counted branch |
| br_taken | output | 1 | Branch decision for the current cycle |
| inj_we | output | 1 | Stage-predicate write enable |
| inj_idx | output | PRED_W (6) | Physical predicate index to write |
| inj_val | output | 1 | Stage-predicate value |
| gr_vnum | input | REG_W (7) | Virtual general register number |
| gr_pnum | output | REG_W (7) | Physical general register number |
| fr_vnum | input | REG_W (7) | Virtual floating register number |
| fr_pnum | output | REG_W (7) | Physical floating register number |
| pr_vnum | input | PRED_W (6) | Virtual predicate number |
| pr_pnum | output | PRED_W (6) | Physical predicate number |
| lc_q | output | LC_W (64) | Loop counter |
| ec_q | output | EC_W (6) | Epilogue counter |
| gr_base | output | 7 | General rotating base |
| fr_base | output | 7 | Floating rotating base |
| pr_base | output | 6 | Predicate rotating base |

## Verification
The hardest state to reach from the ports is a base wrapping past zero for the second time. This matters most where the 48-entry predicate window and the 96-entry general window wrap at different moments. The stimulus gets there by loading a trip count above one hundred and issuing an unbroken run of loop-top branches. That run carries both windows through a full turn and on into the drain phase. A behavioural model tracks the counters and bases and checks the mapping ports every cycle with random virtual numbers, so window edges such as 15, 16, 31, 32, 63 and 127 are exercised at many base values. Same-cycle collisions are driven on purpose: a clear together with a branch, and a setup together with a branch.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    localparam logic KIND_CLOOP = 1'b0;
    localparam logic KIND_CTOP  = 1'b1;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_CLEAR,
        ACT_SETUP,
        ACT_KERNEL,
        ACT_DRAIN,
        ACT_EXIT,
        ACT_CLOOP,
        ACT_CLOOP_END
    } act_e;

    typedef struct packed {
        logic taken;
        logic rotate;
        logic inj_we;
        logic inj_val;
        logic inj_new;   // index taken from the rotated base
    } ctl_t;

    function automatic ctl_t decode_act(act_e a);
        ctl_t c;
        c = '0;
        case (a)
            ACT_SETUP:  begin c.inj_we = 1'b1; c.inj_val = 1'b1; end
            ACT_KERNEL: begin
                c.taken = 1'b1; c.rotate = 1'b1;
                c.inj_we = 1'b1; c.inj_val = 1'b1; c.inj_new = 1'b1;
            end
            ACT_DRAIN:  begin
                c.taken = 1'b1; c.rotate = 1'b1;
                c.inj_we = 1'b1; c.inj_val = 1'b0; c.inj_new = 1'b1;
            end
            ACT_CLOOP:  c.taken = 1'b1;
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rlc_base.sv
module rlc_base #(
    parameter int SIZE = 96,
    localparam int BW  = $clog2(SIZE)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          rot,
    output logic [BW-1:0] base,
    output logic [BW-1:0] base_dec
);
    logic [BW-1:0] base_q;

    // Decrement modulo the window size
    assign base_dec = (base_q == '0) ? BW'(SIZE - 1) : base_q - BW'(1);
    assign base     = base_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            base_q <= '0;
        else if (rot)
            base_q <= base_dec;
    end
endmodule

// File: rtl/rlc_vmap.sv
module rlc_vmap #(
    parameter int W    = 7,
    parameter int LO   = 32,
    parameter int SIZE = 96,
    localparam int BW  = $clog2(SIZE)
) (
    input  logic [W-1:0]  vnum,
    input  logic [BW-1:0] base,
    output logic [W-1:0]  pnum
);
    logic [W:0] off;
    logic [W:0] sum;
    logic       in_win;

    always_comb begin
        in_win = ({1'b0, vnum} >= (W+1)'(LO)) && ({1'b0, vnum} < (W+1)'(LO + SIZE));
        off    = {1'b0, vnum} - (W+1)'(LO);
        sum    = off + (W+1)'(base);
        if (sum >= (W+1)'(SIZE))
            sum = sum - (W+1)'(SIZE);
        sum    = sum + (W+1)'(LO);
        pnum   = in_win ? sum[W-1:0] : vnum;
    end
endmodule

// File: rtl/rlc_count.sv
module rlc_count
    import rlc_pkg::*;
#(
    parameter int LC_W = 64,
    parameter int EC_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            setup_en,
    input  logic [LC_W-1:0] setup_lc,
    input  logic [EC_W-1:0] setup_ec,
    input  logic            br_valid,
    input  logic            br_kind,
    output act_e            act,
    output logic [LC_W-1:0] lc,
    output logic [EC_W-1:0] ec
);
    logic [LC_W-1:0] lc_q;
    logic [EC_W-1:0] ec_q;
    logic            lc_nz, ec_nz;

    assign lc_nz = (lc_q != '0);
    assign ec_nz = (ec_q != '0);

    always_comb begin
        if (clr)
            act = ACT_CLEAR;
        else if (setup_en)
            act = ACT_SETUP;
        else if (!br_valid)
            act = ACT_IDLE;
        else if (br_kind == KIND_CTOP)
            act = lc_nz ? ACT_KERNEL : (ec_nz ? ACT_DRAIN : ACT_EXIT);
        else
            act = lc_nz ? ACT_CLOOP : ACT_CLOOP_END;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lc_q <= '0;
            ec_q <= '0;
        end else begin
            case (act)
                ACT_SETUP: begin
                    lc_q <= setup_lc;
                    ec_q <= setup_ec;
                end
                ACT_KERNEL, ACT_CLOOP: lc_q <= lc_q - LC_W'(1);
                ACT_DRAIN:             ec_q <= ec_q - EC_W'(1);
                default: ;
            endcase
        end
    end

    assign lc = lc_q;
    assign ec = ec_q;
endmodule

// File: rtl/rot_loop_ctrl.sv
module rot_loop_ctrl
    import rlc_pkg::*;
#(
    parameter int LC_W    = 64,
    parameter int EC_W    = 6,
    parameter int REG_W   = 7,
    parameter int PRED_W  = 6,
    parameter int GR_LO   = 32,
    parameter int GR_SIZE = 96,
    parameter int PR_LO   = 16,
    parameter int PR_SIZE = 48,
    localparam int GR_BW  = $clog2(GR_SIZE),
    localparam int PR_BW  = $clog2(PR_SIZE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_bases,
    input  logic              setup_en,
    input  logic [LC_W-1:0]   setup_lc,
    input  logic [EC_W-1:0]   setup_ec,
    input  logic              br_valid,
    input  logic              br_kind,
    output logic              br_taken,
    output logic              inj_we,
    output logic [PRED_W-1:0] inj_idx,
    output logic              inj_val,
    input  logic [REG_W-1:0]  gr_vnum,
    output logic [REG_W-1:0]  gr_pnum,
    input  logic [REG_W-1:0]  fr_vnum,
    output logic [REG_W-1:0]  fr_pnum,
    input  logic [PRED_W-1:0] pr_vnum,
    output logic [PRED_W-1:0] pr_pnum,
    output logic [LC_W-1:0]   lc_q,
    output logic [EC_W-1:0]   ec_q,
    output logic [GR_BW-1:0]  gr_base,
    output logic [GR_BW-1:0]  fr_base,
    output logic [PR_BW-1:0]  pr_base
);
    act_e act;
    ctl_t ctl;

    rlc_count #(.LC_W(LC_W), .EC_W(EC_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_bases),
        .setup_en (setup_en),
        .setup_lc (setup_lc),
        .setup_ec (setup_ec),
        .br_valid (br_valid),
        .br_kind  (br_kind),
        .act      (act),
        .lc       (lc_q),
        .ec       (ec_q)
    );

    assign ctl      = decode_act(act);
    assign br_taken = ctl.taken;

    // General and floating files share one window shape
    logic [1:0][REG_W-1:0] wide_v, wide_p;
    logic [1:0][GR_BW-1:0] wide_b;
    assign wide_v[0] = gr_vnum;
    assign wide_v[1] = fr_vnum;

    for (genvar g = 0; g < 2; g++) begin : g_wide
        logic [GR_BW-1:0] unused_dec;
        rlc_base #(.SIZE(GR_SIZE)) u_base (
            .clk      (clk),
            .rst      (rst),
            .clr      (clr_bases),
            .rot      (ctl.rotate),
            .base     (wide_b[g]),
            .base_dec (unused_dec)
        );
        rlc_vmap #(.W(REG_W), .LO(GR_LO), .SIZE(GR_SIZE)) u_map (
            .vnum (wide_v[g]),
            .base (wide_b[g]),
            .pnum (wide_p[g])
        );
    end

    assign gr_pnum = wide_p[0];
    assign fr_pnum = wide_p[1];
    assign gr_base = wide_b[0];
    assign fr_base = wide_b[1];

    logic [PR_BW-1:0] pr_dec;
    rlc_base #(.SIZE(PR_SIZE)) u_pbase (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_bases),
        .rot      (ctl.rotate),
        .base     (pr_base),
        .base_dec (pr_dec)
    );
    rlc_vmap #(.W(PRED_W), .LO(PR_LO), .SIZE(PR_SIZE)) u_pmap (
        .vnum (pr_vnum),
        .base (pr_base),
        .pnum (pr_pnum)
    );

    // First stage predicate sits at window offset zero
    assign inj_we  = ctl.inj_we;
    assign inj_val = ctl.inj_val;
    assign inj_idx = PRED_W'(PR_LO) + PRED_W'(ctl.inj_new ? pr_dec : pr_base);
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
    parameter int LC_W    = 64,
    parameter int EC_W    = 6,
    parameter int GBW     = 7,
    parameter int PBW     = 6,
    parameter int GR_SIZE = 96,
    parameter int PR_SIZE = 48
) (
    input logic            clk,
    input logic            rst,
    input logic            clr_bases,
    input logic            setup_en,
    input logic            br_valid,
    input logic            br_kind,
    input logic            br_taken,
    input logic            inj_we,
    input logic            inj_val,
    input logic [LC_W-1:0] lc_q,
    input logic [EC_W-1:0] ec_q,
    input logic [GBW-1:0]  gr_base,
    input logic [GBW-1:0]  fr_base,
    input logic [PBW-1:0]  pr_base
);
    logic br_live;
    assign br_live = br_valid && !clr_bases && !setup_en;

    assert_base_range_R2: assert property (@(posedge clk) disable iff (rst)
        (gr_base < GBW'(GR_SIZE)) && (fr_base < GBW'(GR_SIZE)) && (pr_base < PBW'(PR_SIZE)));

    assert_kernel_count_R5: assert property (@(posedge clk) disable iff (rst)
        br_live && br_kind && (lc_q != '0) |=> (lc_q == $past(lc_q) - LC_W'(1)) && $stable(ec_q));

    assert_kernel_inject_R5: assert property (@(posedge clk) disable iff (rst)
        br_live && br_kind && (lc_q != '0) |-> br_taken && inj_we && inj_val);

    assert_taken_needs_count_R5: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (lc_q != '0) || (ec_q != '0));

    assert_drain_R6: assert property (@(posedge clk) disable iff (rst)
        br_live && br_kind && (lc_q == '0) && (ec_q != '0) |-> br_taken && inj_we && !inj_val);

    assert_exit_R7: assert property (@(posedge clk) disable iff (rst)
        br_live && br_kind && (lc_q == '0) && (ec_q == '0)
        |=> $stable(gr_base) && $stable(pr_base) && $stable(lc_q) && $stable(ec_q));

    assert_cloop_R8: assert property (@(posedge clk) disable iff (rst)
        br_live && !br_kind |=> $stable(gr_base) && $stable(fr_base) && $stable(pr_base) && $stable(ec_q));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr_bases |=> (gr_base == '0) && (fr_base == '0) && (pr_base == '0));

    assert_clear_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        clr_bases |-> !br_taken && !inj_we);
endmodule

bind rot_loop_ctrl rlc_checker #(
    .LC_W(LC_W), .EC_W(EC_W), .GBW(GR_BW), .PBW(PR_BW),
    .GR_SIZE(GR_SIZE), .PR_SIZE(PR_SIZE)
) u_chk (
    .clk(clk), .rst(rst), .clr_bases(clr_bases), .setup_en(setup_en),
    .br_valid(br_valid), .br_kind(br_kind), .br_taken(br_taken),
    .inj_we(inj_we), .inj_val(inj_val), .lc_q(lc_q), .ec_q(ec_q),
    .gr_base(gr_base), .fr_base(fr_base), .pr_base(pr_base)
);

// File: tb/rot_loop_ctrl_bench.sv
`timescale 1ns/1ps
module rot_loop_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        clr_bases, setup_en, br_valid, br_kind;
    logic [63:0] setup_lc;
    logic [5:0]  setup_ec;
    logic        br_taken, inj_we, inj_val;
    logic [5:0]  inj_idx;
    logic [6:0]  gr_vnum, gr_pnum, fr_vnum, fr_pnum;
    logic [5:0]  pr_vnum, pr_pnum;
    logic [63:0] lc_q;
    logic [5:0]  ec_q;
    logic [6:0]  gr_base, fr_base;
    logic [5:0]  pr_base;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural model state
    longint unsigned m_lc;
    int m_ec, m_gb, m_fb, m_pb;

    always #5 clk = ~clk;

    rot_loop_ctrl u_rot_loop_ctrl (
        .clk(clk), .rst(rst), .clr_bases(clr_bases), .setup_en(setup_en),
        .setup_lc(setup_lc), .setup_ec(setup_ec), .br_valid(br_valid), .br_kind(br_kind),
        .br_taken(br_taken), .inj_we(inj_we), .inj_idx(inj_idx), .inj_val(inj_val),
        .gr_vnum(gr_vnum), .gr_pnum(gr_pnum), .fr_vnum(fr_vnum), .fr_pnum(fr_pnum),
        .pr_vnum(pr_vnum), .pr_pnum(pr_pnum), .lc_q(lc_q), .ec_q(ec_q),
        .gr_base(gr_base), .fr_base(fr_base), .pr_base(pr_base)
    );

    function automatic int vmap(int v, int lo, int size, int b);
        if (v >= lo && v < lo + size) return lo + ((v - lo + b) % size);
        return v;
    endfunction

    task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_state(string tag);
        chk(tag, "loop count", lc_q, m_lc);
        chk(tag, "epilogue count", ec_q, longint'(m_ec));
        chk(tag, "gr base", gr_base, longint'(m_gb));
        chk(tag, "fr base", fr_base, longint'(m_fb));
        chk(tag, "pr base", pr_base, longint'(m_pb));
    endtask

    // One clock: drive at falling edge, check decisions, then check state
    task automatic cyc(bit c, bit s, longint unsigned slc, int sec, bit bv, bit bk);
        string tag;
        bit e_taken, e_rot, e_we, e_val;
        int e_idx, gv, fv, pv;
        @(negedge clk);
        clr_bases = c; setup_en = s; setup_lc = slc; setup_ec = 6'(sec);
        br_valid = bv; br_kind = bk;
        gv = $urandom_range(127); fv = $urandom_range(127); pv = $urandom_range(63);
        if ($urandom_range(3) == 0) gv = 31 + $urandom_range(1);
        if ($urandom_range(3) == 0) pv = 15 + $urandom_range(1);
        gr_vnum = 7'(gv); fr_vnum = 7'(fv); pr_vnum = 6'(pv);
        e_taken = 0; e_rot = 0; e_we = 0; e_val = 0; e_idx = 16 + m_pb;
        if (c) tag = "R9";
        else if (s) begin tag = bv ? "R10" : "R4"; e_we = 1; e_val = 1; end
        else if (!bv) tag = "R11";
        else if (bk) begin
            if (m_lc != 0) begin tag = "R5"; e_taken = 1; e_rot = 1; e_we = 1; e_val = 1; end
            else if (m_ec != 0) begin tag = "R6"; e_taken = 1; e_rot = 1; e_we = 1; e_val = 0; end
            else tag = "R7";
            if (e_rot) e_idx = 16 + ((m_pb + 47) % 48);
        end else begin
            tag = "R8"; e_taken = (m_lc != 0);
        end
        #1;
        chk(tag, "br_taken", br_taken, e_taken);
        chk(tag, "inj_we", inj_we, e_we);
        if (e_we) begin
            chk(tag, "inj_idx", inj_idx, longint'(e_idx));
            chk(tag, "inj_val", inj_val, e_val);
        end
        chk("R2", "gr map", gr_pnum, longint'(vmap(gv, 32, 96, m_gb)));
        chk("R2", "fr map", fr_pnum, longint'(vmap(fv, 32, 96, m_fb)));
        chk("R3", "pr map", pr_pnum, longint'(vmap(pv, 16, 48, m_pb)));
        @(posedge clk);
        if (c) begin m_gb = 0; m_fb = 0; m_pb = 0; end
        else if (s) begin m_lc = slc; m_ec = sec; end
        else if (bv) begin
            if (bk && m_lc != 0) m_lc--;
            else if (bk && m_ec != 0) m_ec--;
            else if (!bk && m_lc != 0) m_lc--;
            if (e_rot) begin
                m_gb = (m_gb + 95) % 96; m_fb = (m_fb + 95) % 96; m_pb = (m_pb + 47) % 48;
            end
        end
        #1;
        check_state(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; clr_bases = 0; setup_en = 0; br_valid = 0; br_kind = 0;
        setup_lc = '0; setup_ec = '0; gr_vnum = '0; fr_vnum = '0; pr_vnum = '0;
        m_lc = 0; m_ec = 0; m_gb = 0; m_fb = 0; m_pb = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        check_state("R1");
        chk("R1", "inj_we idle", inj_we, 0);
        cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
        // Drain of a three-trip loop with two epilogue stages
        cyc(0, 1, 3, 2, 0, 0);
        for (int i = 0; i < 7; i++) cyc(0, 0, 0, 0, 1, 1);
        // Setup colliding with a branch, then clear colliding with a branch
        cyc(0, 1, 5, 1, 1, 1);
        cyc(0, 0, 0, 0, 1, 1); cyc(0, 0, 0, 0, 1, 1);
        cyc(1, 0, 0, 0, 1, 1);
        cyc(1, 1, 9, 9, 1, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, 1);
        // Plain counted loop
        cyc(0, 1, 2, 3, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 0);
        // Long run: both windows wrap more than once
        cyc(0, 1, 110, 3, 0, 0);
        for (int i = 0; i < 116; i++) cyc(0, 0, 0, 0, 1, 1);
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule